// File: doc/BRIEF.md
# TPM Command/Response FIFO Controller

This block holds the command and response state of a TPM-style register interface for a single locality. A host talks to it through a byte-wide register port with two targets: a status register and a data FIFO. The host writes a command byte by byte into a shared buffer and starts it with a go request. The block then hands the byte count to a backend, which writes its response into the same buffer and signals completion. The host reads the response back through the FIFO. A status read returns the status flags together with a burst count, which tells the host how many bytes it may move next.

The command length is taken from the command header, so the block knows when a command is complete. The host can abort, retry a response read or restart at any point through three status-write codes. The backend reaches the buffer through its own byte port. A cancel request asks it to stop early.

Top module: `tpm_cmd_fifo_ctrl`

## Requirements
- R1: After reset the block is idle. The status byte holds only the family bits (bits 7:6, a parameter), the self-test-done bit (bit 4) is clear, and the burst count equals the buffer depth.
- R2: A status write (select 0) acts only when bits 2:0 are exactly 3'b001 (command ready), 3'b010 (go) or 3'b100 (retry); any other value has no effect. Command ready in idle moves the block to ready, sets the command-ready bit (bit 1) and pulses the command-ready interrupt.
- R3: The first FIFO write (select 1) in ready stores its byte, moves the block to reception, sets expect (bit 3) and valid (bit 0), clears command ready and pulses the status-valid interrupt. FIFO writes in idle, execution or completion are dropped.
- R4: The declared command length is the 32-bit big-endian value in buffer bytes 2 to 5. Once more than five bytes are held, expect stays set while the byte count is below that length and clears when it is reached. Further writes are then dropped.
- R5: Go acts only in reception with expect clear. The block then enters execution and pulses the execute request for one cycle, with the execute length equal to the byte count.
- R6: A completion pulse in execution moves the block to completion, sets valid and data-available (bit 2), rewinds the pointer and pulses both the data-available and status-valid interrupts.
- R7: In completion with data-available set, FIFO reads return the response bytes in buffer order. The response length is the header length capped at the depth. After the last byte, data-available clears and status-valid pulses. Any other FIFO read returns 0xFF.
- R8: Retry in completion rewinds the read pointer and sets valid and data-available again.
- R9: The burst count (read-data bits 23:8) is the number of unread response bytes while data-available is set, and the free buffer space otherwise. A one-byte status read caps it at 255.
- R10: A completion pulse with the self-test flag sets self-test-done. Every status update keeps self-test-done and the family bits, and self-test-done stays set until reset.
- R11: Command ready in completion goes to ready, rewinds, clears data-available, sets command ready and pulses its interrupt. Command ready in ready only rewinds the pointer.
- R12: Command ready in reception aborts at once to ready, with command ready set and its interrupt pulsed. In execution it pulses the cancel request, and the next completion returns to ready the same way, with no data-available interrupt. A completion in the same cycle as command ready goes straight to ready without a cancel.
- R13: When the buffer is full and expect is still set, a further FIFO write is dropped, expect clears and valid is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe (ignored while reg_wr_i is high) |
| reg_sel_i | input | 1 | Register target: 0 status, 1 data FIFO |
| reg_byte_i | input | 1 | Status read is a one-byte access |
| reg_wdata_i | input | 8 | Host write byte |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read strobe |
| rd_data_o | output | 32 | Read data: FIFO byte in bits 7:0, or {8'h0, burst count, status byte} |
| exec_req_o | output | 1 | One-cycle execute request to the backend |
| exec_len_o | output | PW | Command length handed to the backend |
| cancel_req_o | output | 1 | One-cycle cancel request to the backend |
| done_i | input | 1 | Backend completion pulse |
| selftest_i | input | 1 | Completion reports that the self-test finished |
| be_wr_i | input | 1 | Backend buffer write strobe |
| be_addr_i | input | AW | Backend buffer address |
| be_wdata_i | input | 8 | Backend buffer write byte |
| be_rdata_o | output | 8 | Backend buffer read byte at be_addr_i |
| irq_cmd_ready_o | output | 1 | Command-ready interrupt pulse |
| irq_sts_valid_o | output | 1 | Status-valid interrupt pulse |
| irq_data_avail_o | output | 1 | Data-available interrupt pulse |

## Verification
The backend completion pulse and a host command-ready write can fall in the same cycle while a command executes. Both try to decide the next state. The bench drives the completion strobe and the status write on the same clock edge. It then judges the result at the ports: no cancel request, a command-ready interrupt without a data-available interrupt, and a status byte that shows ready with data-available clear. It also runs the sequential form, a cancel followed by a later completion, and expects the same final status.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_READY = 3'd1,
        ST_RECV = 3'd2,
        ST_EXEC = 3'd3,
        ST_COMPL = 3'd4
    } tcf_state_e;

    typedef struct packed {
        logic [1:0] family;
        logic       rsvd;
        logic       selftest;
        logic       expect_more;
        logic       data_avail;
        logic       cmd_ready;
        logic       valid;
    } tcf_sts_t;

    localparam logic [7:0] F_VALID = 8'h01;
    localparam logic [7:0] F_CMDRDY = 8'h02;
    localparam logic [7:0] F_AVAIL = 8'h04;
    localparam logic [7:0] F_EXPECT = 8'h08;

    localparam logic [2:0] WR_CMD_READY = 3'b001;
    localparam logic [2:0] WR_GO = 3'b010;
    localparam logic [2:0] WR_RETRY = 3'b100;

    localparam logic SEL_STS = 1'b0;
    localparam logic SEL_FIFO = 1'b1;

    // Replace the transient flags, keep self-test-done and family.
    function automatic tcf_sts_t sts_keep(tcf_sts_t cur, logic [7:0] flags);
        tcf_sts_t o;
        o = tcf_sts_t'(flags & 8'h0F);
        o.family = cur.family;
        o.selftest = cur.selftest;
        return o;
    endfunction

endpackage

// File: rtl/tcf_byte_buf.sv
module tcf_byte_buf #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/tcf_burst_calc.sv
module tcf_burst_calc #(
    parameter int DEPTH = 256,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic [PW-1:0] ptr,
    input  logic [PW-1:0] rsp_len,
    input  logic          avail,
    input  logic          byte_rd,
    output logic [15:0]   burst
);
    logic [PW-1:0] remain;

    always_comb begin
        remain = avail ? (rsp_len - ptr) : (PW'(DEPTH) - ptr);
        burst = 16'(remain);
        if (byte_rd && (burst > 16'd255)) begin
            burst = 16'd255;
        end
    end
endmodule

// File: rtl/tpm_cmd_fifo_ctrl.sv
module tpm_cmd_fifo_ctrl
    import tcf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter logic [1:0] FAMILY = 2'b10,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic          reg_sel_i,
    input  logic          reg_byte_i,
    input  logic [7:0]    reg_wdata_i,
    output logic          rd_valid_o,
    output logic [31:0]   rd_data_o,
    output logic          exec_req_o,
    output logic [PW-1:0] exec_len_o,
    output logic          cancel_req_o,
    input  logic          done_i,
    input  logic          selftest_i,
    input  logic          be_wr_i,
    input  logic [AW-1:0] be_addr_i,
    input  logic [7:0]    be_wdata_i,
    output logic [7:0]    be_rdata_o,
    output logic          irq_cmd_ready_o,
    output logic          irq_sts_valid_o,
    output logic          irq_data_avail_o
);
    typedef struct packed {
        tcf_state_e    st;
        tcf_sts_t      sts;
        logic [PW-1:0] ptr;
        logic [PW-1:0] exec_len;
        logic [31:0]   len;
        logic          abort;
        logic          exec_req;
        logic          cancel;
        logic          irq_cr;
        logic          irq_sv;
        logic          irq_da;
        logic          rd_valid;
        logic [31:0]   rd_data;
    } regs_t;

    regs_t r_q, r_d;

    logic          host_we;
    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [7:0]    buf_wdata;
    logic [7:0]    host_rdata;
    logic [PW-1:0] rsp_len;
    logic [15:0]   burst;
    logic          st_wr, ff_wr, st_rd, ff_rd;
    logic          do_cr, do_go, do_retry, exec_done;
    logic [PW:0]   cnt_next;

    // Monitor copies for the bound checker.
    tcf_state_e    st_mon;
    tcf_sts_t      sts_mon;
    logic [PW-1:0] ptr_mon;
    logic          abort_mon;

    assign st_mon = r_q.st;
    assign sts_mon = r_q.sts;
    assign ptr_mon = r_q.ptr;
    assign abort_mon = r_q.abort;

    function automatic logic [31:0] put_len(logic [31:0] cur, logic [2:0] off,
                                            logic [7:0] b);
        logic [31:0] o;
        o = cur;
        case (off)
            3'd2: o[31:24] = b;
            3'd3: o[23:16] = b;
            3'd4: o[15:8] = b;
            3'd5: o[7:0] = b;
            default: o = cur;
        endcase
        return o;
    endfunction

    assign rsp_len = (r_q.len > 32'(DEPTH)) ? PW'(DEPTH) : r_q.len[PW-1:0];

    assign st_wr = reg_wr_i && (reg_sel_i == SEL_STS);
    assign ff_wr = reg_wr_i && (reg_sel_i == SEL_FIFO);
    assign st_rd = reg_rd_i && !reg_wr_i && (reg_sel_i == SEL_STS);
    assign ff_rd = reg_rd_i && !reg_wr_i && (reg_sel_i == SEL_FIFO);
    assign do_cr = st_wr && (reg_wdata_i[2:0] == WR_CMD_READY);
    assign do_go = st_wr && (reg_wdata_i[2:0] == WR_GO);
    assign do_retry = st_wr && (reg_wdata_i[2:0] == WR_RETRY);
    assign exec_done = done_i && (r_q.st == ST_EXEC);
    assign cnt_next = {1'b0, r_q.ptr} + 1'b1;

    tcf_byte_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (r_q.ptr[AW-1:0]),
        .rdata_a (host_rdata),
        .raddr_b (be_addr_i),
        .rdata_b (be_rdata_o)
    );

    tcf_burst_calc #(.DEPTH(DEPTH)) u_burst (
        .ptr     (r_q.ptr),
        .rsp_len (rsp_len),
        .avail   (r_q.sts.data_avail),
        .byte_rd (reg_byte_i),
        .burst   (burst)
    );

    always_comb begin
        r_d = r_q;
        r_d.exec_req = 1'b0;
        r_d.cancel = 1'b0;
        r_d.irq_cr = 1'b0;
        r_d.irq_sv = 1'b0;
        r_d.irq_da = 1'b0;
        r_d.rd_valid = 1'b0;
        host_we = 1'b0;

        // Host FIFO write path.
        if (ff_wr) begin
            if (r_q.st == ST_READY) begin
                r_d.st = ST_RECV;
                r_d.sts = sts_keep(r_q.sts, F_EXPECT | F_VALID);
                r_d.irq_sv = !r_q.sts.valid;
            end
            if ((r_q.st == ST_READY) ||
                ((r_q.st == ST_RECV) && r_q.sts.expect_more)) begin
                if (r_q.ptr < PW'(DEPTH)) begin
                    host_we = 1'b1;
                    r_d.ptr = cnt_next[PW-1:0];
                    if (r_q.ptr < PW'(6)) begin
                        r_d.len = put_len(r_q.len, r_q.ptr[2:0], reg_wdata_i);
                    end
                    if (cnt_next > (PW+1)'(5)) begin
                        r_d.sts.expect_more = (r_d.len > 32'(cnt_next));
                        r_d.sts.valid = 1'b1;
                    end
                end else begin
                    r_d.sts.expect_more = 1'b0;
                    r_d.sts.valid = 1'b1;
                end
            end
        end

        // Backend writes update the header length when the host is not storing.
        if (!host_we && be_wr_i && (be_addr_i < AW'(6))) begin
            r_d.len = put_len(r_q.len, be_addr_i[2:0], be_wdata_i);
        end

        // Host status writes.
        if (do_cr) begin
            case (r_q.st)
                ST_IDLE, ST_RECV: begin
                    r_d.st = ST_READY;
                    r_d.ptr = '0;
                    r_d.sts = sts_keep(r_q.sts, F_CMDRDY);
                    r_d.irq_cr = 1'b1;
                end
                ST_READY: begin
                    r_d.ptr = '0;
                end
                ST_EXEC: begin
                    if (!done_i) begin
                        r_d.cancel = 1'b1;
                        r_d.abort = 1'b1;
                    end
                end
                ST_COMPL: begin
                    r_d.st = ST_READY;
                    r_d.ptr = '0;
                    if (!r_q.sts.cmd_ready) begin
                        r_d.sts = sts_keep(r_q.sts, F_CMDRDY);
                        r_d.irq_cr = 1'b1;
                    end
                    r_d.sts.data_avail = 1'b0;
                end
                default: r_d.st = r_q.st;
            endcase
        end

        if (do_go && (r_q.st == ST_RECV) && !r_q.sts.expect_more) begin
            r_d.st = ST_EXEC;
            r_d.exec_req = 1'b1;
            r_d.exec_len = r_q.ptr;
        end

        if (do_retry && (r_q.st == ST_COMPL)) begin
            r_d.ptr = '0;
            r_d.sts = sts_keep(r_q.sts, F_VALID | F_AVAIL);
        end

        // Backend completion.
        if (exec_done) begin
            r_d.ptr = '0;
            if (r_q.abort || do_cr) begin
                r_d.st = ST_READY;
                r_d.sts = sts_keep(r_q.sts, F_CMDRDY);
                r_d.irq_cr = 1'b1;
                r_d.abort = 1'b0;
            end else begin
                r_d.st = ST_COMPL;
                r_d.sts = sts_keep(r_q.sts, F_VALID | F_AVAIL);
                r_d.irq_da = 1'b1;
                r_d.irq_sv = 1'b1;
            end
            if (selftest_i) begin
                r_d.sts.selftest = 1'b1;
            end
        end

        // Host reads.
        if (ff_rd) begin
            r_d.rd_valid = 1'b1;
            r_d.rd_data = 32'h0000_00FF;
            if ((r_q.st == ST_COMPL) && r_q.sts.data_avail) begin
                r_d.rd_data = {24'h0, host_rdata};
                r_d.ptr = cnt_next[PW-1:0];
                if (cnt_next >= (PW+1)'(rsp_len)) begin
                    r_d.sts = sts_keep(r_q.sts, F_VALID);
                    r_d.irq_sv = 1'b1;
                end
            end
        end
        if (st_rd) begin
            r_d.rd_valid = 1'b1;
            r_d.rd_data = {8'h0, burst, r_q.sts};
        end
    end

    always_comb begin
        buf_we = host_we || be_wr_i;
        buf_waddr = host_we ? r_q.ptr[AW-1:0] : be_addr_i;
        buf_wdata = host_we ? reg_wdata_i : be_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            r_q.sts.family <= FAMILY;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_valid_o = r_q.rd_valid;
    assign rd_data_o = r_q.rd_data;
    assign exec_req_o = r_q.exec_req;
    assign exec_len_o = r_q.exec_len;
    assign cancel_req_o = r_q.cancel;
    assign irq_cmd_ready_o = r_q.irq_cr;
    assign irq_sts_valid_o = r_q.irq_sv;
    assign irq_data_avail_o = r_q.irq_da;
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker
    import tcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input tcf_state_e    st,
    input tcf_sts_t      sts,
    input logic [PW-1:0] ptr,
    input logic          abort,
    input logic          done_i,
    input logic          reg_wr_i,
    input logic          reg_sel_i,
    input logic [7:0]    reg_wdata_i,
    input logic          exec_req_o,
    input logic          irq_data_avail_o
);
    logic cr_write;
    assign cr_write = reg_wr_i && (reg_sel_i == SEL_STS) &&
                      (reg_wdata_i[2:0] == WR_CMD_READY);

    assert_leave_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (st != ST_IDLE));

    assert_go_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_EXEC) |-> (($past(st) == ST_RECV) && !$past(sts.expect_more)));

    assert_exec_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req_o |=> !exec_req_o);

    assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_EXEC) && done_i && !abort && !cr_write) |=>
        ((st == ST_COMPL) && sts.data_avail && sts.valid && irq_data_avail_o));

    assert_selftest_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sts.selftest |=> sts.selftest);

    assert_family_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sts.family));

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(DEPTH));
endmodule

bind tpm_cmd_fifo_ctrl tcf_checker #(.DEPTH(DEPTH)) u_tcf_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .st               (st_mon),
    .sts              (sts_mon),
    .ptr              (ptr_mon),
    .abort            (abort_mon),
    .done_i           (done_i),
    .reg_wr_i         (reg_wr_i),
    .reg_sel_i        (reg_sel_i),
    .reg_wdata_i      (reg_wdata_i),
    .exec_req_o       (exec_req_o),
    .irq_data_avail_o (irq_data_avail_o)
);

// File: tb/tb_tpm_cmd_fifo_ctrl.sv
module tb_tpm_cmd_fifo_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0, reg_byte = 1'b0;
    logic [7:0]    reg_wdata = 8'h0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          exec_req, cancel_req;
    logic [PW-1:0] exec_len;
    logic          done = 1'b0, selftest = 1'b0;
    logic          be_wr = 1'b0;
    logic [AW-1:0] be_addr = '0;
    logic [7:0]    be_wdata = 8'h0;
    logic [7:0]    be_rdata;
    logic          irq_cr, irq_sv, irq_da;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic cap_cr, cap_sv, cap_da, cap_exec, cap_cancel;
    logic [31:0] word;
    logic [7:0]  byte_v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tpm_cmd_fifo_ctrl #(.DEPTH(DEPTH), .FAMILY(2'b10)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_wr_i         (reg_wr),
        .reg_rd_i         (reg_rd),
        .reg_sel_i        (reg_sel),
        .reg_byte_i       (reg_byte),
        .reg_wdata_i      (reg_wdata),
        .rd_valid_o       (rd_valid),
        .rd_data_o        (rd_data),
        .exec_req_o       (exec_req),
        .exec_len_o       (exec_len),
        .cancel_req_o     (cancel_req),
        .done_i           (done),
        .selftest_i       (selftest),
        .be_wr_i          (be_wr),
        .be_addr_i        (be_addr),
        .be_wdata_i       (be_wdata),
        .be_rdata_o       (be_rdata),
        .irq_cmd_ready_o  (irq_cr),
        .irq_sts_valid_o  (irq_sv),
        .irq_data_avail_o (irq_da)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic capture();
        cap_cr = irq_cr;
        cap_sv = irq_sv;
        cap_da = irq_da;
        cap_exec = exec_req;
        cap_cancel = cancel_req;
    endtask

    // Every op starts and ends at a falling edge.
    task automatic wr_reg(input logic sel, input logic [7:0] b);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = b;
        @(negedge clk);
        reg_wr = 1'b0;
        capture();
    endtask

    task automatic rd_sts(input logic one_byte, output logic [31:0] w);
        reg_rd = 1'b1; reg_sel = 1'b0; reg_byte = one_byte;
        @(negedge clk);
        reg_rd = 1'b0; reg_byte = 1'b0;
        w = rd_data;
    endtask

    task automatic rd_fifo(output logic [7:0] b);
        reg_rd = 1'b1; reg_sel = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        capture();
        b = rd_data[7:0];
    endtask

    task automatic expect_sts(input string tag, input logic [7:0] s, input int burst);
        logic [31:0] w;
        rd_sts(1'b0, w);
        chk({tag, " status"}, {24'h0, w[7:0]}, {24'h0, s});
        chk({tag, " burst"}, {16'h0, w[23:8]}, 32'(burst));
    endtask

    function automatic logic [7:0] cmd_byte(input int i, input logic [31:0] len);
        case (i)
            0: return 8'h80;
            1: return 8'h01;
            2: return len[31:24];
            3: return len[23:16];
            4: return len[15:8];
            5: return len[7:0];
            default: return 8'(i) ^ 8'h5A;
        endcase
    endfunction

    task automatic send_cmd(input logic [31:0] len, input int from, input int upto);
        for (int i = from; i < upto; i++) wr_reg(1'b1, cmd_byte(i, len));
    endtask

    task automatic be_response(input int n);
        for (int i = 0; i < n; i++) begin
            be_wr = 1'b1; be_addr = AW'(i);
            be_wdata = (i < 6) ? cmd_byte(i, 32'(n)) : (8'hA0 + 8'(i));
            @(negedge clk);
        end
        be_wr = 1'b0;
    endtask

    task automatic pulse_done(input logic st_flag);
        done = 1'b1; selftest = st_flag;
        @(negedge clk);
        done = 1'b0; selftest = 1'b0;
        capture();
    endtask

    task automatic t_reset();
        expect_sts("R1 reset", 8'h80, 256);
    endtask

    task automatic t_idle();
        wr_reg(1'b1, 8'h11);
        expect_sts("R3 idle write dropped", 8'h80, 256);
        rd_fifo(byte_v);
        chk("R7 idle read", {24'h0, byte_v}, 32'hFF);
        wr_reg(1'b0, 8'h03);
        chk("R2 mixed bits no irq", {31'h0, cap_cr}, 32'h0);
        expect_sts("R2 mixed bits ignored", 8'h80, 256);
        wr_reg(1'b0, 8'h01);
        chk("R2 idle to ready irq", {31'h0, cap_cr}, 32'h1);
        expect_sts("R2 ready", 8'h82, 256);
        rd_sts(1'b1, word);
        chk("R9 byte read saturates", {16'h0, word[23:8]}, 32'd255);
        wr_reg(1'b0, 8'h01);
        chk("R11 ready cr no irq", {31'h0, cap_cr}, 32'h0);
        expect_sts("R11 ready cr", 8'h82, 256);
    endtask

    task automatic t_command();
        wr_reg(1'b1, cmd_byte(0, 32'd10));
        chk("R3 first write sv irq", {31'h0, cap_sv}, 32'h1);
        expect_sts("R3 reception", 8'h89, 255);
        send_cmd(32'd10, 1, 6);
        expect_sts("R4 still expecting", 8'h89, 250);
        wr_reg(1'b0, 8'h02);
        chk("R5 go with expect", {31'h0, cap_exec}, 32'h0);
        send_cmd(32'd10, 6, 10);
        expect_sts("R4 complete", 8'h81, 246);
        wr_reg(1'b1, 8'h77);
        expect_sts("R4 extra dropped", 8'h81, 246);
        wr_reg(1'b0, 8'h02);
        chk("R5 exec pulse", {31'h0, cap_exec}, 32'h1);
        chk("R5 exec len", 32'(exec_len), 32'd10);
        wr_reg(1'b1, 8'h33);
        expect_sts("R3 exec write dropped", 8'h81, 246);
        for (int i = 0; i < 10; i++) begin
            be_addr = AW'(i);
            #1;
            chk("R4 stored byte", {24'h0, be_rdata}, {24'h0, cmd_byte(i, 32'd10)});
        end
        @(negedge clk);
    endtask

    task automatic t_response();
        be_response(8);
        pulse_done(1'b1);
        chk("R6 da irq", {31'h0, cap_da}, 32'h1);
        chk("R6 sv irq", {31'h0, cap_sv}, 32'h1);
        expect_sts("R6 R10 completion", 8'h95, 8);
        for (int i = 0; i < 3; i++) begin
            rd_fifo(byte_v);
            chk("R7 response byte", {24'h0, byte_v}, {24'h0, cmd_byte(i, 32'd8)});
        end
        expect_sts("R9 remaining", 8'h95, 5);
        wr_reg(1'b0, 8'h04);
        expect_sts("R8 retry", 8'h95, 8);
        for (int i = 0; i < 8; i++) begin
            rd_fifo(byte_v);
            chk("R7 reread byte", {24'h0, byte_v},
                {24'h0, (i < 6) ? cmd_byte(i, 32'd8) : (8'hA0 + 8'(i))});
        end
        chk("R7 last byte sv irq", {31'h0, cap_sv}, 32'h1);
        expect_sts("R7 drained", 8'h91, 248);
        rd_fifo(byte_v);
        chk("R7 read after drain", {24'h0, byte_v}, 32'hFF);
        wr_reg(1'b0, 8'h01);
        chk("R11 compl cr irq", {31'h0, cap_cr}, 32'h1);
        expect_sts("R11 compl to ready", 8'h92, 256);
    endtask

    task automatic t_abort_recv();
        send_cmd(32'd20, 0, 3);
        wr_reg(1'b0, 8'h01);
        chk("R12 recv abort irq", {31'h0, cap_cr}, 32'h1);
        expect_sts("R12 recv abort", 8'h92, 256);
    endtask

    task automatic t_abort_exec();
        send_cmd(32'd6, 0, 6);
        expect_sts("R4 six bytes", 8'h91, 250);
        wr_reg(1'b0, 8'h02);
        wr_reg(1'b0, 8'h01);
        chk("R12 cancel pulse", {31'h0, cap_cancel}, 32'h1);
        expect_sts("R12 still exec", 8'h91, 250);
        pulse_done(1'b0);
        chk("R12 abort cr irq", {31'h0, cap_cr}, 32'h1);
        chk("R12 abort no da irq", {31'h0, cap_da}, 32'h0);
        expect_sts("R12 R10 abort ready", 8'h92, 256);
    endtask

    task automatic t_same_cycle();
        send_cmd(32'd6, 0, 6);
        wr_reg(1'b0, 8'h02);
        done = 1'b1;
        wr_reg(1'b0, 8'h01);
        done = 1'b0;
        chk("R12 same cycle no cancel", {31'h0, cap_cancel}, 32'h0);
        chk("R12 same cycle cr irq", {31'h0, cap_cr}, 32'h1);
        chk("R12 same cycle no da", {31'h0, cap_da}, 32'h0);
        expect_sts("R12 same cycle ready", 8'h92, 256);
    endtask

    task automatic t_full();
        send_cmd(32'h1000, 0, DEPTH);
        expect_sts("R13 buffer full", 8'h99, 0);
        wr_reg(1'b1, 8'hEE);
        expect_sts("R13 overflow write", 8'h91, 0);
        wr_reg(1'b0, 8'h02);
        chk("R13 exec len full", 32'(exec_len), 32'(DEPTH));
        be_response(6);
        pulse_done(1'b0);
        expect_sts("R10 selftest kept", 8'h95, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_command();
        t_response();
        t_abort_recv();
        t_abort_exec();
        t_same_cycle();
        t_full();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule